// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one virtual address at a time into a physical address. It walks a two-level page table held in memory. A translation request brings a virtual address, a read/write access type and a supervisor-mode flag. The request is sampled together with the current page table base. The walker then issues one word read per level on a simple request/response memory port.

The top index field selects an entry in the first-level table. That entry supplies the base of a second-level table. The middle index field then selects the leaf entry, which supplies the physical page number. An invalid entry at either level stops the walk with a page fault. A valid leaf is checked against the access before any address is produced: supervisor-only pages are closed to user mode, reads need the read bit, and writes need the write bit.

The result is shown for a single cycle: a status code, and on success the physical page number joined to the untouched page offset. Only one walk is in progress at a time. The `busy` output tells the requester when a new request will be taken.

Top module: `page_walker`

## Requirements
- R1: After reset `busy`, `done` and `memReqValid` are all 0.
- R2: A request (`reqValid` high) is accepted only while `busy` is 0. `busy` is 1 from the next cycle through the cycle in which `done` is high. `reqValid` raised while `busy` is 1 has no effect on the walk in progress.
- R3: The first memory read goes to the page table base, with its two low bits forced to 0, plus four times VA[31:22].
- R4: A first-level entry with bit 0 (valid) equal to 0 ends the walk with status 1 (page fault) and no second memory read.
- R5: The second memory read goes to {first-level entry[31:12], 12'h000} plus four times VA[21:12].
- R6: A leaf entry with bit 0 equal to 0 gives status 1 (page fault).
- R7: A valid leaf whose permission bits deny the access gives status 2 (protection fault) with `physAddr` 0. The bits are bit 1 read allowed, bit 2 write allowed and bit 3 supervisor-only. The access is denied when a user access (`reqSuper`=0) meets bit 3 set, when a read meets bit 1 clear, or when a write meets bit 2 clear.
- R8: A permitted valid leaf gives status 0 and `physAddr` = {leaf[31:12], VA[11:0]}. Any fault status comes with `physAddr` 0.
- R9: `done` is high for exactly one cycle per walk, and `busy` falls in the cycle after it. Each memory read is a one-cycle `memReqValid` pulse on a word-aligned address.
- R10: The walker waits any number of cycles in a wait state for `memRspValid`. No result appears before the response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqSuper | input | 1 | 1 = supervisor mode, 0 = user mode |
| tableBase | input | 32 | Base address of the first-level table |
| busy | output | 1 | Walk in progress; requests are ignored |
| memReqValid | output | 1 | Memory word read request |
| memReqAddr | output | 32 | Byte address of the requested entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle result strobe |
| status | output | 2 | 0 success, 1 page fault, 2 protection fault |
| physAddr | output | 32 | Physical address on success, else 0 |

## Verification
Suppose the walker held a wrong state or a corrupted latched request. The error would show at the memory port within one cycle of acceptance, as a wrong or repeated read address. It could also show as a second read after an invalid first-level entry. A wrong permission decision, or a lost page offset, shows in the `done` cycle as a wrong status or address. The bench therefore checks every read address and the final result of every walk. It sweeps all leaf permission and valid combinations against both access types and both privilege modes, with varying response latency.

// File: rtl/walk_pkg.sv
package walk_pkg;

  typedef enum logic [1:0] {
    WALK_OK    = 2'd0,
    WALK_PAGE  = 2'd1,
    WALK_PROT  = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
  } walk_state_e;

  typedef struct packed {
    logic loadReq;     // latch request fields
    logic loadL1;      // latch next-table base from level-1 entry
    logic useL2;       // select level-2 entry address
    logic endL1Fault;  // finish with page fault at level 1
    logic endLeaf;     // finish with evaluation of leaf entry
  } walk_strobe_t;

  localparam int ENT_VALID = 0;
  localparam int ENT_READ  = 1;
  localparam int ENT_WRITE = 2;
  localparam int ENT_SUPER = 3;

endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  logic         rspValidBit,
  output walk_strobe_t strobe,
  output logic         busy,
  output logic         done,
  output logic         memReqValid
);

  walk_state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    memReqValid = 1'b0;
    done        = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          stateD         = S_L1_REQ;
        end
      end
      S_L1_REQ: begin
        memReqValid = 1'b1;
        stateD      = S_L1_WAIT;
      end
      S_L1_WAIT: begin
        if (memRspValid) begin
          if (rspValidBit) begin
            strobe.loadL1 = 1'b1;
            stateD        = S_L2_REQ;
          end else begin
            strobe.endL1Fault = 1'b1;
            stateD            = S_DONE;
          end
        end
      end
      S_L2_REQ: begin
        strobe.useL2 = 1'b1;
        memReqValid  = 1'b1;
        stateD       = S_L2_WAIT;
      end
      S_L2_WAIT: begin
        strobe.useL2 = 1'b1;
        if (memRspValid) begin
          strobe.endLeaf = 1'b1;
          stateD         = S_DONE;
        end
      end
      S_DONE: begin
        done   = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqValid) |=> !busy);

endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 12,
  parameter int IDX_W    = 10,
  parameter int ENT_SHIFT = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  walk_strobe_t                  strobe,
  input  logic [2*IDX_W+OFFSET_W-1:0]   reqVaddr,
  input  logic                          reqWrite,
  input  logic                          reqSuper,
  input  logic [ADDR_W-1:0]             tableBase,
  input  logic [ADDR_W-1:0]             memRspData,
  output logic [ADDR_W-1:0]             memReqAddr,
  output logic                          rspValidBit,
  output logic [1:0]                    status,
  output logic [ADDR_W-1:0]             physAddr
);

  localparam int VA_W  = 2*IDX_W + OFFSET_W;
  localparam int PPN_W = ADDR_W - OFFSET_W;

  logic [VA_W-1:0]   vaQ;
  logic              wrQ, supQ;
  logic [ADDR_W-1:0] baseQ;
  logic [PPN_W-1:0]  nextBaseQ;
  walk_status_e      statusQ;
  logic [ADDR_W-1:0] paQ;

  logic [IDX_W-1:0]  vpnHi, vpnLo;
  logic [ADDR_W-1:0] l1Addr, l2Addr;
  logic              denySup, denyRd, denyWr, leafDenied;

  assign vpnHi = vaQ[VA_W-1 -: IDX_W];
  assign vpnLo = vaQ[OFFSET_W +: IDX_W];

  assign l1Addr = {baseQ[ADDR_W-1:ENT_SHIFT], {ENT_SHIFT{1'b0}}}
                + (ADDR_W'(vpnHi) << ENT_SHIFT);
  assign l2Addr = {nextBaseQ, {OFFSET_W{1'b0}}}
                + (ADDR_W'(vpnLo) << ENT_SHIFT);

  assign memReqAddr  = strobe.useL2 ? l2Addr : l1Addr;
  assign rspValidBit = memRspData[ENT_VALID];

  assign denySup    = !supQ && memRspData[ENT_SUPER];
  assign denyRd     = !wrQ  && !memRspData[ENT_READ];
  assign denyWr     =  wrQ  && !memRspData[ENT_WRITE];
  assign leafDenied = denySup || denyRd || denyWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      wrQ       <= 1'b0;
      supQ      <= 1'b0;
      baseQ     <= '0;
      nextBaseQ <= '0;
      statusQ   <= WALK_OK;
      paQ       <= '0;
    end else begin
      if (strobe.loadReq) begin
        vaQ   <= reqVaddr;
        wrQ   <= reqWrite;
        supQ  <= reqSuper;
        baseQ <= tableBase;
      end
      if (strobe.loadL1) nextBaseQ <= memRspData[ADDR_W-1:OFFSET_W];
      if (strobe.endL1Fault) begin
        statusQ <= WALK_PAGE;
        paQ     <= '0;
      end else if (strobe.endLeaf) begin
        if (!memRspData[ENT_VALID]) begin
          statusQ <= WALK_PAGE;
          paQ     <= '0;
        end else if (leafDenied) begin
          statusQ <= WALK_PROT;
          paQ     <= '0;
        end else begin
          statusQ <= WALK_OK;
          paQ     <= {memRspData[ADDR_W-1:OFFSET_W], vaQ[OFFSET_W-1:0]};
        end
      end
    end
  end

  assign status   = statusQ;
  assign physAddr = paQ;

  assert_fault_no_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (status != WALK_OK) |-> (physAddr == '0));

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.endLeaf && memRspData[ENT_VALID] && !leafDenied)
      |=> (physAddr[OFFSET_W-1:0] == $past(vaQ[OFFSET_W-1:0])));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 12,
  parameter int IDX_W     = 10,
  parameter int ENT_SHIFT = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [2*IDX_W+OFFSET_W-1:0] reqVaddr,
  input  logic                        reqWrite,
  input  logic                        reqSuper,
  input  logic [ADDR_W-1:0]           tableBase,
  output logic                        busy,
  output logic                        memReqValid,
  output logic [ADDR_W-1:0]           memReqAddr,
  input  logic                        memRspValid,
  input  logic [ADDR_W-1:0]           memRspData,
  output logic                        done,
  output logic [1:0]                  status,
  output logic [ADDR_W-1:0]           physAddr
);

  walk_strobe_t strobe;
  logic         rspValidBit;

  walk_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .rspValidBit (rspValidBit),
    .strobe      (strobe),
    .busy        (busy),
    .done        (done),
    .memReqValid (memReqValid)
  );

  walk_dpath #(
    .ADDR_W    (ADDR_W),
    .OFFSET_W  (OFFSET_W),
    .IDX_W     (IDX_W),
    .ENT_SHIFT (ENT_SHIFT)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .reqSuper    (reqSuper),
    .tableBase   (tableBase),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .rspValidBit (rspValidBit),
    .status      (status),
    .physAddr    (physAddr)
  );

  assert_addr_aligned_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[ENT_SHIFT-1:0] == '0));

  assert_status_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (status != 2'd3));

  assert_done_while_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: tb/page_walker_tb_top.sv
module page_walker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqSuper = 1'b0;
  logic [31:0] tableBase = '0;
  logic        busy, memReqValid, done;
  logic [31:0] memReqAddr, physAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [1:0]  status;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  page_walker dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .tableBase(tableBase),
    .busy(busy), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .done(done), .status(status), .physAddr(physAddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic respond(input logic [31:0] data, input int lat);
    repeat (lat) begin
      @(negedge clk);
      chk(!done && !memReqValid, "R10 idle while waiting", {30'd0, done, memReqValid}, 32'd0);
    end
    memRspValid = 1'b1;
    memRspData  = data;
    @(negedge clk);
    memRspValid = 1'b0;
    memRspData  = 32'hDEAD_BEEF;
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input bit sup,
                      input logic [31:0] base, input logic [31:0] l1,
                      input logic [31:0] l2, input int lat, input bit poke);
    logic [31:0] e1, e2, ePa;
    logic [1:0]  eSt;
    e1 = {base[31:2], 2'b00} + {20'd0, va[31:22], 2'b00};
    e2 = {l1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    if (!l2[0]) eSt = 2'd1;
    else if ((!sup && l2[3]) || (!wr && !l2[1]) || (wr && !l2[2])) eSt = 2'd2;
    else eSt = 2'd0;
    ePa = (eSt == 2'd0) ? {l2[31:12], va[11:0]} : 32'd0;

    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqSuper = sup; tableBase = base;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R2 busy after accept", {31'd0, busy}, 32'd1);
    chk(memReqValid && memReqAddr == e1, "R3 level-1 address", memReqAddr, e1);
    @(negedge clk);
    chk(!memReqValid, "R9 one-cycle request", {31'd0, memReqValid}, 32'd0);
    if (poke) begin
      reqValid = 1'b1; reqVaddr = ~va; tableBase = ~base; reqWrite = ~wr;
    end
    respond(l1, lat);
    reqValid = 1'b0;
    if (!l1[0]) begin
      chk(done && status == 2'd1, "R4 level-1 page fault", {30'd0, status}, 32'd1);
      chk(!memReqValid, "R4 no second read", {31'd0, memReqValid}, 32'd0);
      chk(physAddr == 32'd0, "R8 fault address zero", physAddr, 32'd0);
    end else begin
      chk(memReqValid && memReqAddr == e2, "R5 level-2 address", memReqAddr, e2);
      @(negedge clk);
      chk(!memReqValid, "R9 one-cycle request", {31'd0, memReqValid}, 32'd0);
      respond(l2, lat);
      chk(done, "R9 done raised", {31'd0, done}, 32'd1);
      if (eSt == 2'd1)      chk(status == eSt, "R6 leaf page fault", {30'd0, status}, {30'd0, eSt});
      else if (eSt == 2'd2) chk(status == eSt, "R7 protection fault", {30'd0, status}, {30'd0, eSt});
      else                  chk(status == eSt, "R8 success status", {30'd0, status}, {30'd0, eSt});
      chk(physAddr == ePa, (eSt == 2'd2) ? "R7 no address on deny" : "R8 physical address", physAddr, ePa);
    end
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle then idle", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReqValid, "R1 reset outputs", {29'd0, busy, done, memReqValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid, "R1 idle after reset", {29'd0, busy, done, memReqValid}, 32'd0);

    // R6 R7 R8: all leaf flag combinations against access type and mode
    for (int perm = 0; perm < 16; perm++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int sup = 0; sup < 2; sup++) begin
          logic [31:0] va, base, l1, l2;
          va   = 32'h1234_5678 * (perm + 1) + 32'h0003_1000 * (wr + 2 * sup);
          base = 32'h0010_0000 + 32'h0000_4000 * perm + wr * 3;
          l1   = {20'h40000 + 20'(perm * 7 + wr), 12'h001};
          l2   = {20'h80000 + 20'(perm * 13 + sup), 8'h00, 4'(perm)};
          walk(va, wr[0], sup[0], base, l1, l2, (perm + wr) % 4, 1'b0);
        end
      end
    end

    // R4: invalid level-1 entries, with and without other flag bits
    for (int k = 0; k < 4; k++) begin
      walk(32'hFFC0_0000 >> k, k[0], k[1], 32'h0020_0000 + k,
           {20'h12345, 8'h00, 4'(k * 2) & 4'hE}, 32'h0000_000F, k, 1'b0);
    end

    // R2: requests raised during a walk are ignored; R10 long latency
    walk(32'hABCD_E123, 1'b0, 1'b1, 32'h0030_0000, 32'h5555_5001, 32'h7777_700B, 5, 1'b1);
    walk(32'h0000_0FFF, 1'b1, 1'b0, 32'h0000_0000, 32'hFFFF_F001, 32'hFFFF_F007, 9, 1'b1);

    // R3 R5 boundaries: top and bottom indices
    walk(32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_F000, 32'hFFFF_F001, 32'h0000_100F, 0, 1'b0);
    walk(32'h0000_0000, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_0001, 32'h0000_1003, 1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule